// File: doc/BRIEF.md
# Conversion Result Register with Interrupt and DMA Request

This block sits between an analog-to-digital conversion engine and a 16-bit peripheral register port. Each time the engine reports a finished conversion, the block stores the sample in a result register and sets a data-ready flag. If the previous sample had not been read yet, it also sets an overrun flag. Each flag has its own interrupt enable. Both sources drive one shared, level-sensitive interrupt line. Software reads the status register to find which source is active.

Every finished conversion also produces a one-cycle DMA request, so a DMA engine can drain results to memory without software help.

Reading the result register clears the data-ready flag. Writing 1 to the overrun bit clears that flag.

The register port uses byte offsets. The result register is at 0x0 and the control/status register is at 0x4. Offsets 0x2 and 0x6 belong to engine controls that live elsewhere, so this block reads them as zero.

Top module: `adc_result_irq`

## Requirements
- R1: After reset the result register, both flags and both enables are 0, `irq` is 0 and `dma_req` is 0.
- R2: A cycle with `conv_done` high loads `conv_data` into the result register (offset 0x0) and sets the data-ready flag (status bit 0) at that clock edge.
- R3: A `bus_rd` cycle at offset 0x0 clears the data-ready flag at that edge, unless a completion arrives in the same cycle.
- R4: A completion that arrives while the data-ready flag is 1, with no result read in the same cycle, sets the overrun flag (status bit 1) and replaces the stored result.
- R5: Writing offset 0x4 with bit 1 set clears the overrun flag. Writing 0 to bit 1 leaves the flag unchanged. Bit 0 is read-only.
- R6: Status bit 2 is the data-ready interrupt enable and bit 3 is the overrun interrupt enable. Both are written and read at offset 0x4. `irq` is high exactly when (bit0 and bit2) or (bit1 and bit3).
- R7: When a completion and a result read happen in the same cycle, the data-ready flag stays 1 and the overrun flag is not set.
- R8: `dma_req` is high for exactly the one cycle after each clock edge at which the result register was loaded, and low otherwise.
- R9: Status bits 15:4 and offsets 0x2 and 0x6 always read 0, whatever is written to them.
- R10: When an overrun-setting completion and a write of 1 to bit 1 happen in the same cycle, the overrun flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data | input | 16 | Conversion result, valid with `conv_done` |
| bus_addr | input | 3 | Register byte offset |
| bus_rd | input | 1 | Read strobe (has side effects at offset 0x0) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Shared level interrupt request |
| dma_req | output | 1 | One-cycle DMA request per completion |

## Verification
The assertions assume the following about the inputs:
- `conv_done` is a strobe, and each high cycle carries one fresh sample.
- `bus_rd` and `bus_wr` are never high in the same cycle.
- Every access uses one of the four even offsets.

The stimulus keeps within these limits. It drives at most one bus operation per cycle, changes every input only on the falling edge, and returns to an idle status-register address between steps. It still deliberately overlaps a completion with a result read, and a completion with an overrun-clearing write, because those overlaps are defined behaviour.

// File: rtl/adc_result_irq.sv
module adc_result_irq #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              dma_req
);
  localparam logic [ADDR_W-1:0] OFS_RESULT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(4);
  localparam int B_RDY = 0;
  localparam int B_OVR = 1;
  localparam int B_RIE = 2;
  localparam int B_OIE = 3;

  logic [DATA_W-1:0] result_q;
  logic rdy_q, ovr_q, rie_q, oie_q, dma_q;

  wire rd_result = bus_rd && (bus_addr == OFS_RESULT);
  wire wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  wire ovr_set   = conv_done && rdy_q && !rd_result;
  wire ovr_clr   = wr_ctrl && bus_wdata[B_OVR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      rdy_q    <= 1'b0;
      ovr_q    <= 1'b0;
      rie_q    <= 1'b0;
      oie_q    <= 1'b0;
      dma_q    <= 1'b0;
    end else begin
      dma_q <= conv_done;
      if (conv_done) result_q <= conv_data;
      if (conv_done)      rdy_q <= 1'b1;
      else if (rd_result) rdy_q <= 1'b0;
      if (ovr_set)        ovr_q <= 1'b1;
      else if (ovr_clr)   ovr_q <= 1'b0;
      if (wr_ctrl) begin
        rie_q <= bus_wdata[B_RIE];
        oie_q <= bus_wdata[B_OIE];
      end
    end
  end

  logic [DATA_W-1:0] status;
  always_comb begin
    status        = '0;
    status[B_RDY] = rdy_q;
    status[B_OVR] = ovr_q;
    status[B_RIE] = rie_q;
    status[B_OIE] = oie_q;
  end

  assign bus_rdata = (bus_addr == OFS_RESULT) ? result_q :
                     (bus_addr == OFS_CTRL)   ? status   : '0;
  assign irq     = (rdy_q && rie_q) || (ovr_q && oie_q);
  assign dma_req = dma_q;
endmodule

module adc_result_irq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_data,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              irq,
  input logic              dma_req,
  input logic              rdy_q,
  input logic              ovr_q,
  input logic [DATA_W-1:0] result_q
);
  wire rd_res = bus_rd && (bus_addr == '0);

  // R2
  load_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (rdy_q && result_q == $past(conv_data)));
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !conv_done) |=> !rdy_q);
  // R4
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rdy_q && !rd_res) |=> ovr_q);
  // R7
  same_cycle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rd_res && !ovr_q) |=> (rdy_q && !ovr_q));
  // R8
  dma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> dma_req);
  // R8
  dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !dma_req);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result_q));
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rdy_q || ovr_q));
endmodule

bind adc_result_irq adc_result_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .irq(irq), .dma_req(dma_req),
  .rdy_q(rdy_q), .ovr_q(ovr_q), .result_q(result_q)
);

// File: tb/tb_adc_result_irq.sv
module tb_adc_result_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_done = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] conv_data = '0, bus_wdata = '0;
  logic [2:0] bus_addr = 3'd4;
  logic [15:0] bus_rdata;
  logic irq, dma_req;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_result_irq dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  // {cd, data[16], rd, wr, addr[3], wdata[16], exp_status[4], exp_irq, exp_dma}
  localparam int NV = 11;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 16'hA5A5, 1'b0, 1'b0, 3'd4, 16'h0000, 4'h1, 1'b0, 1'b1},
    {1'b0, 16'h0000, 1'b0, 1'b1, 3'd4, 16'h0004, 4'h5, 1'b1, 1'b0},
    {1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 16'h0000, 4'h4, 1'b0, 1'b0},
    {1'b1, 16'h1234, 1'b0, 1'b0, 3'd4, 16'h0000, 4'h5, 1'b1, 1'b1},
    {1'b1, 16'h5678, 1'b0, 1'b0, 3'd4, 16'h0000, 4'h7, 1'b1, 1'b1},
    {1'b0, 16'h0000, 1'b0, 1'b1, 3'd4, 16'h000C, 4'hF, 1'b1, 1'b0},
    {1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 16'h0000, 4'hE, 1'b1, 1'b0},
    {1'b0, 16'h0000, 1'b0, 1'b1, 3'd4, 16'h000E, 4'hC, 1'b0, 1'b0},
    {1'b1, 16'h9999, 1'b1, 1'b0, 3'd0, 16'h0000, 4'hD, 1'b1, 1'b1},
    {1'b1, 16'h7777, 1'b0, 1'b1, 3'd4, 16'h000E, 4'hF, 1'b1, 1'b1},
    {1'b0, 16'h0000, 1'b0, 1'b1, 3'd4, 16'h0002, 4'h1, 1'b0, 1'b0}
  };
  localparam string VTAG [NV] = '{"R2 R8", "R6", "R3", "R2 R8", "R4",
    "R5 R6", "R3 R6", "R5", "R7", "R10", "R5 R6"};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    conv_done = 0; bus_rd = 0; bus_wr = 0; bus_addr = 3'd4; bus_wdata = '0;
  endtask

  task automatic read_at(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 3'd4;
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1
    check("R1 status", bus_rdata, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 dma", {15'd0, dma_req}, 16'd0);
    read_at(3'd0, d); check("R1 result", d, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {conv_done, conv_data, bus_rd, bus_wr, bus_addr, bus_wdata} = VEC[i][43:6];
      @(negedge clk);
      idle(); #1;
      check(VTAG[i], bus_rdata, {12'd0, VEC[i][5:2]});
      check({VTAG[i], " irq"}, {15'd0, irq}, {15'd0, VEC[i][1]});
      check({VTAG[i], " dma"}, {15'd0, dma_req}, {15'd0, VEC[i][0]});
    end

    // R4: latest sample replaced the unread one
    read_at(3'd0, d); check("R4 result", d, 16'h7777);
    // R8: pulse lasts a single cycle
    @(negedge clk); conv_data = 16'h0F0F; conv_done = 1;
    @(negedge clk); idle(); #1; check("R8 pulse", {15'd0, dma_req}, 16'd1);
    @(negedge clk); #1; check("R8 single", {15'd0, dma_req}, 16'd0);
    // R3: read clears, then no further change without completion
    @(negedge clk); bus_rd = 1; bus_addr = 3'd0; #1; d = bus_rdata;
    check("R2 result", d, 16'h0F0F);
    @(negedge clk); idle(); #1; check("R3 cleared", bus_rdata, 16'h0002);
    // R9: reserved bits and unused offsets
    @(negedge clk); bus_wr = 1; bus_addr = 3'd4; bus_wdata = 16'hFFF3;
    @(negedge clk); idle(); #1; check("R9 reserved", bus_rdata, 16'h0000);
    @(negedge clk); bus_wr = 1; bus_addr = 3'd2; bus_wdata = 16'hFFFF;
    @(negedge clk); idle();
    read_at(3'd2, d); check("R9 offset2", d, 16'h0000);
    read_at(3'd6, d); check("R9 offset6", d, 16'h0000);
    // R1: reset clears everything again
    @(negedge clk); bus_wr = 1; bus_wdata = 16'h000C; conv_done = 1; conv_data = 16'h1111;
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    check("R1 rereset", bus_rdata, 16'h0000);
    read_at(3'd0, d); check("R1 rereset result", d, 16'h0000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule